// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when a processor core leaves ordinary in-order retirement for runahead mode, and when it comes back. When the oldest instruction in the window is stuck behind a long-latency miss, the controller remembers the address of that miss. It pulses a strobe that snapshots the architectural register state into a small checkpoint bank. It then raises a runahead flag, which also grants pseudo-retirement. Instructions may leave the window without committing, and the loads they issue become prefetch candidates.

Runahead loads feed a small prefetch queue. The queue sends addresses out over a valid/ready handshake, oldest first. An address that is already waiting in the queue is not added a second time. A load that arrives while the queue is full is discarded, so runahead never stalls. A wrong prefetch therefore only costs bandwidth.

Runahead ends only when a memory response carries the remembered miss address. At that point the queue is emptied. Then a single restore cycle pulses both the restore strobe and the pipeline flush. After that, the core is back in normal mode and re-executes from the missing instruction, using the checkpointed state that the bank presents.

Top module: `runahead_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ckpt_save, ckpt_restore, flush, ra_mode, pseudo_retire and pf_valid are all low.
- R2: A high miss_valid in normal mode makes ckpt_save high for exactly the next cycle. ra_mode and pseudo_retire go high in the cycle after that, and stay high until runahead ends.
- R3: The checkpoint bank captures arch_state in the cycle when ckpt_save is high. ckpt_state keeps that value through runahead and the restore cycle.
- R4: Runahead ends only on a cycle where resp_valid is high and resp_addr equals the miss_addr latched on entry. Any other response leaves the mode unchanged.
- R5: The cycle after the exiting response, ckpt_restore and flush are high for exactly one cycle, with ra_mode low. The controller is in normal mode the following cycle.
- R6: A high miss_valid while ra_mode is high causes no second ckpt_save.
- R7: Loads with ld_valid high are queued only while ra_mode is high. The queue presents the oldest address on pf_addr with pf_valid high, and removes it in a cycle where pf_ready is high.
- R8: The queue holds 4 addresses. A load that arrives while it is full is discarded and never shows up on pf_addr.
- R9: A load whose address equals one already held in the queue is not added.
- R10: The exiting response empties the queue, so pf_valid is low in the restore cycle. A load in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Oldest instruction blocked by a long-latency miss |
| miss_addr | input | 16 | Address of that miss |
| resp_valid | input | 1 | Memory response present |
| resp_addr | input | 16 | Address carried by the response |
| ld_valid | input | 1 | Load issued during runahead |
| ld_addr | input | 16 | Address of that load |
| pf_ready | input | 1 | Memory side accepts a prefetch |
| arch_state | input | 64 | Architectural registers, 4 x 16 bits |
| ckpt_save | output | 1 | Checkpoint-save strobe |
| ckpt_restore | output | 1 | Checkpoint-restore strobe |
| flush | output | 1 | Flush of speculative pipeline contents |
| ra_mode | output | 1 | Runahead mode active |
| pseudo_retire | output | 1 | Instructions may leave the window uncommitted |
| pf_valid | output | 1 | Prefetch request present |
| pf_addr | output | 16 | Prefetch request address |
| ckpt_state | output | 64 | Checkpointed register state |

## Verification
All outputs come from registers, so every result lands one clock edge after the input that causes it. The save strobe follows a miss by one edge, and ra_mode rises one edge later. The restore/flush pulse follows the matching response by one edge, and normal mode returns one edge after that. A queued load is visible on pf_addr one edge after it is issued. The bench drives each vector on the falling edge and checks the outputs one nanosecond later. At that point the outputs reflect only the edges already passed, so each vector lists the outputs expected for the state built by the vectors before it.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_SAVE    = 2'd1,
        MODE_RUN     = 2'd2,
        MODE_RECOVER = 2'd3
    } ra_mode_e;
endpackage

// File: rtl/ckpt_bank.sv
module ckpt_bank #(
    parameter int NREG = 4,
    parameter int DW   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               save,
    input  logic [NREG*DW-1:0] state_in,
    output logic [NREG*DW-1:0] state_out
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] reg_d, reg_q;
        always_comb begin
            reg_d = reg_q;
            if (save) reg_d = state_in[g*DW +: DW];
        end
        always_ff @(posedge clk) begin
            if (rst) reg_q <= '0;
            else     reg_q <= reg_d;
        end
        assign state_out[g*DW +: DW] = reg_q;
    end

    // R3: the saved value persists while no save strobe is present
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !save |=> $stable(state_out));
endmodule

// File: rtl/pf_queue.sv
module pf_queue #(
    parameter int AW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic          valid,
    output logic [AW-1:0] head
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [CW-1:0]            cnt;
    } q_t;

    q_t q_d, q_q;
    logic dup, full, do_pop, do_push;
    logic [CW-1:0] slot;

    always_comb begin
        q_d  = q_q;
        dup  = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i) < q_q.cnt && q_q.ent[i] == push_addr) dup = 1'b1;
        full    = (q_q.cnt == CW'(DEPTH));
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push_valid && !full && !dup;
        slot    = q_q.cnt - CW'(do_pop);
        if (clr) begin
            q_d.cnt = '0;
        end else begin
            if (do_pop) begin
                for (int i = 0; i < DEPTH - 1; i++) q_d.ent[i] = q_q.ent[i+1];
            end
            if (do_push) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == slot) q_d.ent[i] = push_addr;
            end
            q_d.cnt = q_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    assign valid = (q_q.cnt != '0);
    assign head  = q_q.ent[0];

    // R8: a full queue without a pop stays full and never grows
    a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clr) |=> (q_q.cnt == CW'(DEPTH)));
    // R10: clearing leaves nothing to present
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !valid);
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
    parameter int AW    = 16,
    parameter int NREG  = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    input  logic [AW-1:0]      miss_addr,
    input  logic               resp_valid,
    input  logic [AW-1:0]      resp_addr,
    input  logic               ld_valid,
    input  logic [AW-1:0]      ld_addr,
    input  logic               pf_ready,
    input  logic [NREG*DW-1:0] arch_state,
    output logic               ckpt_save,
    output logic               ckpt_restore,
    output logic               flush,
    output logic               ra_mode,
    output logic               pseudo_retire,
    output logic               pf_valid,
    output logic [AW-1:0]      pf_addr,
    output logic [NREG*DW-1:0] ckpt_state
);
    import ra_pkg::*;

    typedef struct packed {
        ra_mode_e      mode;
        logic [AW-1:0] trig;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic exit_hit;

    always_comb begin
        ctl_d    = ctl_q;
        exit_hit = (ctl_q.mode == MODE_RUN) && resp_valid && (resp_addr == ctl_q.trig);
        case (ctl_q.mode)
            MODE_NORMAL: if (miss_valid) begin
                ctl_d.mode = MODE_SAVE;
                ctl_d.trig = miss_addr;
            end
            MODE_SAVE:    ctl_d.mode = MODE_RUN;
            MODE_RUN:     if (exit_hit) ctl_d.mode = MODE_RECOVER;
            MODE_RECOVER: ctl_d.mode = MODE_NORMAL;
            default:      ctl_d.mode = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{mode: MODE_NORMAL, trig: '0};
        else     ctl_q <= ctl_d;
    end

    assign ckpt_save     = (ctl_q.mode == MODE_SAVE);
    assign ckpt_restore  = (ctl_q.mode == MODE_RECOVER);
    assign flush         = (ctl_q.mode == MODE_RECOVER);
    assign ra_mode       = (ctl_q.mode == MODE_RUN);
    assign pseudo_retire = (ctl_q.mode == MODE_RUN);

    ckpt_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .save      (ckpt_save),
        .state_in  (arch_state),
        .state_out (ckpt_state)
    );

    pf_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .clr        (exit_hit),
        .push_valid (ld_valid && ra_mode),
        .push_addr  (ld_addr),
        .pop        (pf_ready),
        .valid      (pf_valid),
        .head       (pf_addr)
    );

    // R2: the save strobe lasts one cycle and leads into runahead
    a_r2_save_then_run: assert property (@(posedge clk) disable iff (rst)
        ckpt_save |=> (ra_mode && !ckpt_save));
    a_r2_run_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(ra_mode) |-> $past(ckpt_save));
    // R4: exit only on a response matching the latched miss
    a_r4_exit_on_match: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |-> $past(resp_valid && resp_addr == ctl_q.trig && ra_mode));
    // R5: restore lasts one cycle and returns to normal
    a_r5_restore_once: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |=> (!ckpt_restore && !ra_mode && !ckpt_save));
    // R6: no nested checkpoint
    a_r6_no_nest: assert property (@(posedge clk) disable iff (rst)
        (ra_mode && miss_valid) |=> !ckpt_save);
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ckpt_save, ckpt_restore, ra_mode}));
endmodule

// File: tb/sim_runahead_ctrl.sv
`timescale 1ns/1ps
module sim_runahead_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 0, resp_valid = 0, ld_valid = 0, pf_ready = 0;
    logic [15:0] miss_addr = 0, resp_addr = 0, ld_addr = 0;
    logic [63:0] arch_state = 0;
    logic        ckpt_save, ckpt_restore, flush, ra_mode, pseudo_retire, pf_valid;
    logic [15:0] pf_addr;
    logic [63:0] ckpt_state;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    runahead_ctrl u0 (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .pf_ready(pf_ready), .arch_state(arch_state),
        .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore), .flush(flush),
        .ra_mode(ra_mode), .pseudo_retire(pseudo_retire), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .ckpt_state(ckpt_state)
    );

    typedef struct packed {
        logic miss; logic [15:0] maddr;
        logic resp; logic [15:0] raddr;
        logic ld;   logic [15:0] laddr;
        logic rdy;
        logic e_save, e_rest, e_ra, e_pfv; logic [15:0] e_pfa;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0050, 1'b0, 1'b0,1'b0,1'b0,1'b0,16'h0000}, // R7 load in normal ignored
        '{1'b1,16'h0100, 1'b1,16'h0100, 1'b0,16'h0000, 1'b0, 1'b0,1'b0,1'b0,1'b0,16'h0000}, // R4 response outside runahead
        '{1'b1,16'h0100, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b1,1'b0,1'b0,1'b0,16'h0000}, // R2 save cycle
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0200, 1'b0, 1'b0,1'b0,1'b1,1'b0,16'h0000},
        '{1'b1,16'h0300, 1'b0,16'h0000, 1'b1,16'h0210, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0200}, // R6 nested miss
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0200, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0200}, // R9 duplicate
        '{1'b0,16'h0000, 1'b1,16'h0200, 1'b1,16'h0220, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0200}, // R4 prefetch response
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0230, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0200},
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h02F0, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0200}, // R8 full drop
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 1'b0,1'b0,1'b1,1'b1,16'h0200},
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 1'b0,1'b0,1'b1,1'b1,16'h0210},
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0240, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0220},
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 1'b0,1'b0,1'b1,1'b1,16'h0220},
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 1'b0,1'b0,1'b1,1'b1,16'h0230},
        '{1'b0,16'h0000, 1'b1,16'h0100, 1'b1,16'h0250, 1'b0, 1'b0,1'b0,1'b1,1'b1,16'h0240}, // R4 matching exit, R10 load dropped
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,1'b1,1'b0,1'b0,16'h0000}, // R5 restore, R10 empty
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,1'b0,1'b0,1'b0,16'h0000}  // R5 back to normal
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, {ckpt_save, ckpt_restore, flush, ra_mode, pseudo_retire, pf_valid}, 64'h0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst = 1'b0;
        @(negedge clk); #1;
        check_idle("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            miss_valid = VECS[i].miss; miss_addr = VECS[i].maddr;
            resp_valid = VECS[i].resp; resp_addr = VECS[i].raddr;
            ld_valid   = VECS[i].ld;   ld_addr   = VECS[i].laddr;
            pf_ready   = VECS[i].rdy;
            arch_state = {4{16'h1000 + 16'(i)}};
            #1;
            check("R2 save", 64'(ckpt_save), 64'(VECS[i].e_save));
            check("R5 restore", 64'(ckpt_restore), 64'(VECS[i].e_rest));
            check("R5 flush", 64'(flush), 64'(VECS[i].e_rest));
            check("R2 ra_mode", 64'(ra_mode), 64'(VECS[i].e_ra));
            check("R2 pseudo_retire", 64'(pseudo_retire), 64'(VECS[i].e_ra));
            check("R7 pf_valid", 64'(pf_valid), 64'(VECS[i].e_pfv));
            if (VECS[i].e_pfv) check("R7 pf_addr", 64'(pf_addr), 64'(VECS[i].e_pfa));
        end
        // R3: value present in the save cycle (vector 2) is held
        check("R3 checkpoint", ckpt_state, {4{16'h1002}});

        // R1: reset in the middle of runahead with a queued prefetch
        @(negedge clk);
        miss_valid = 1; miss_addr = 16'h0400; ld_valid = 0; resp_valid = 0; pf_ready = 0;
        @(negedge clk); miss_valid = 0;
        @(negedge clk); ld_valid = 1; ld_addr = 16'h0500;
        @(negedge clk); ld_valid = 0; #1;
        check("R7 queued after re-entry", {pf_valid, 16'(pf_addr)}, {1'b1, 16'h0500});
        check("R2 second entry", 64'(ra_mode), 64'h1);
        rst = 1'b1;
        @(negedge clk); #1;
        check_idle("R1 reset mid-runahead");
        rst = 1'b0;
        @(negedge clk); #1;
        check_idle("R1 idle after reset");
        finish_run();
    end
endmodule